// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends bytes on an asynchronous serial line using a fixed frame of one start bit, eight data bits sent least significant bit first, and one stop bit. A one-byte holding register sits in front of the shift register. Software can therefore queue the next byte as soon as the current one has moved into the shifter. When a byte is waiting, consecutive frames go out with no idle time between them.

Bit timing comes from an external baud tick. Each bit lasts a fixed number of ticks. Software watches two flags, `buf_full_o` and `tx_busy_o`. The buffer flag alone tells software whether it may write. The busy flag tells it whether a frame is still on the line. A one-cycle completion pulse marks the end of every frame. If software writes while the buffer is occupied, the write is dropped and a sticky overrun flag is set. A request to re-initialise the transmit side is honoured only while the buffer is empty.

Top module: `uart_dbuf_tx`

## Requirements
- R1: After reset, `tx_o` is 1 and `buf_full_o`, `tx_busy_o`, `tx_done_o` and `overrun_o` are all 0.
- R2: A write (`wr_en_i`=1) while `buf_full_o`=0 stores `wr_data_i` and sets `buf_full_o` in the next cycle.
- R3: When the buffer is full and the shifter is idle, the byte moves to the shifter on the next cycle with `baud_tick_i`=1. In the following cycle `buf_full_o` is 0 and `tx_busy_o` is 1. When the buffer is full at the tick that ends a stop bit, the next start bit begins right away with no idle tick.
- R4: A frame on `tx_o` is one 0 start bit, then the eight data bits LSB first, then one 1 stop bit. Each bit lasts 16 baud ticks. While idle, `tx_o` is 1.
- R5: `tx_busy_o` is 1 from the transfer into the shifter until the last tick of the last stop bit. It then returns to 0 if no byte is waiting.
- R6: In back-to-back use, the flag pair {`buf_full_o`,`tx_busy_o`} reads 10 after the first write, 01 after the transfer, 11 after a second write, and 01 again after the second transfer.
- R7: A write while `buf_full_o`=1 is dropped. It sets `overrun_o` in the next cycle. It changes neither the buffered byte nor the frame being shifted.
- R8: `overrun_o` stays 1 until `ovr_clr_i` is 1. If a clear and a new overrun fall in the same cycle, the overrun wins.
- R9: `tx_done_o` pulses for exactly one cycle in the cycle after the tick that ends each stop bit. This includes frames that are immediately followed by another frame.
- R10: `init_i` with `buf_full_o`=0 returns the shifter to idle in the next cycle (`tx_busy_o`=0, `tx_o`=1) and gives no `tx_done_o` pulse. `init_i` with `buf_full_o`=1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| baud_tick_i | input | 1 | One-cycle baud tick, 16 per bit |
| wr_en_i | input | 1 | Buffer write strobe |
| wr_data_i | input | 8 | Byte to queue |
| init_i | input | 1 | Transmit-side initialise request |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| tx_o | output | 1 | Serial output, idle high |
| buf_full_o | output | 1 | Buffer holds a byte not yet taken |
| tx_busy_o | output | 1 | Frame in progress |
| tx_done_o | output | 1 | One-cycle end-of-frame pulse |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The bench covers back-to-back frames. A design that waits an idle tick before the second start bit, or that drops the completion pulse between chained frames, falls out of step with the model on `tx_o` and `tx_done_o`. The bench writes into a full buffer. A design that lets that write overwrite the held byte sends the wrong data bits. It sends a clear in the same cycle as an overrun, which exposes a design where the clear wins. It sends an initialise request while a byte waits, which a design that ignores the buffer flag would honour, and it sends one mid-frame, which must cut the frame short silently. Sparse baud ticks check that bit length is counted in ticks, not in clocks.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  parameter int unsigned DEF_DATA_W = 8;
  parameter int unsigned DEF_OVS    = 16;

  typedef struct packed {
    logic full;
    logic busy;
  } tx_flags_t;
endpackage

// File: rtl/uart_tx_buf.sv
module uart_tx_buf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  input  logic              ovr_clr_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ovr_o
);
  logic              full_q, ovr_q;
  logic [DATA_W-1:0] data_q;
  logic              wr_ok, wr_bad;

  assign wr_ok  = wr_en_i & ~full_q;
  assign wr_bad = wr_en_i &  full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (wr_ok) begin
        full_q <= 1'b1;
        data_q <= wr_data_i;
      end else if (take_i) begin
        full_q <= 1'b0;
      end
      // set beats clear
      if (wr_bad)         ovr_q <= 1'b1;
      else if (ovr_clr_i) ovr_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
  assign ovr_o  = ovr_q;

  // R7
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && full_q |=> ovr_q);
  // R7
  buf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && full_q |=> data_q == $past(data_q));
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              buf_full_i,
  input  logic [DATA_W-1:0] buf_data_i,
  input  logic              init_i,
  output logic              take_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              tx_o
);
  localparam int unsigned FRAME_BITS = DATA_W + 2;
  localparam int unsigned BIT_W      = $clog2(FRAME_BITS);
  localparam int unsigned TICK_W     = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(FRAME_BITS - 1);
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(OVS - 1);

  logic              busy_q, done_q;
  logic [BIT_W-1:0]  bit_q;
  logic [TICK_W-1:0] tick_q;
  logic [DATA_W-1:0] sh_q;
  logic              bit_end, frame_end, init_ok;

  assign bit_end   = busy_q & (tick_q == LAST_TICK);
  assign frame_end = bit_end & (bit_q == LAST_BIT);
  assign init_ok   = init_i & ~buf_full_i;
  assign take_o    = tick_i & buf_full_i & (~busy_q | frame_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      bit_q  <= '0;
      tick_q <= '0;
      sh_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (init_ok) begin
        busy_q <= 1'b0;
        bit_q  <= '0;
        tick_q <= '0;
      end else if (take_o) begin
        done_q <= busy_q;  // chained frame ends here
        busy_q <= 1'b1;
        bit_q  <= '0;
        tick_q <= '0;
        sh_q   <= buf_data_i;
      end else if (tick_i && busy_q) begin
        if (bit_end) begin
          tick_q <= '0;
          if (frame_end) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            if (bit_q != '0) sh_q <= sh_q >> 1;
          end
        end else begin
          tick_q <= tick_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (!busy_q)               tx_o = 1'b1;
    else if (bit_q == '0)      tx_o = 1'b0;
    else if (bit_q == LAST_BIT) tx_o = 1'b1;
    else                       tx_o = sh_q[0];
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R3
  take_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> busy_q && !buf_full_i);
  // R10
  init_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i && !buf_full_i |=> !busy_q && tx_o && !done_q);
  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned OVS    = DEF_OVS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              init_i,
  input  logic              ovr_clr_i,
  output logic              tx_o,
  output logic              buf_full_o,
  output logic              tx_busy_o,
  output logic              tx_done_o,
  output logic              overrun_o
);
  logic              take;
  logic [DATA_W-1:0] buf_data;
  tx_flags_t         flags;

  uart_tx_buf #(.DATA_W(DATA_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .take_i    (take),
    .ovr_clr_i (ovr_clr_i),
    .full_o    (flags.full),
    .data_o    (buf_data),
    .ovr_o     (overrun_o)
  );

  uart_tx_shift #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (baud_tick_i),
    .buf_full_i (flags.full),
    .buf_data_i (buf_data),
    .init_i     (init_i),
    .take_o     (take),
    .busy_o     (flags.busy),
    .done_o     (tx_done_o),
    .tx_o       (tx_o)
  );

  assign buf_full_o = flags.full;
  assign tx_busy_o  = flags.busy;

  // R4
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy_o |-> tx_o);
endmodule

// File: tb/sim_uart_dbuf_tx.sv
`timescale 1ns/1ps
module sim_uart_dbuf_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       init = 1'b0;
  logic       ovr_clr = 1'b0;
  logic       tx_o, buf_full_o, tx_busy_o, tx_done_o, overrun_o;

  int total = 0, bad = 0;
  int tick_per = 1, tick_div = 0;
  bit tick_en = 1'b0;
  bit finished = 1'b0;

  // reference model state
  bit   m_full = 0, m_busy = 0, m_done = 0, m_ovr = 0;
  int   m_cnt = 0;
  byte  m_q[$];
  logic [7:0] m_sh = '0;

  always #2 clk = ~clk;

  uart_dbuf_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .init_i(init), .ovr_clr_i(ovr_clr),
    .tx_o(tx_o), .buf_full_o(buf_full_o), .tx_busy_o(tx_busy_o),
    .tx_done_o(tx_done_o), .overrun_o(overrun_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_tx();
    if (!m_busy) return 1'b1;
    if (m_cnt < 16) return 1'b0;
    if (m_cnt >= 144) return 1'b1;
    return m_sh[(m_cnt / 16) - 1];
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      bit old_full, take, init_ok;
      old_full = m_full;
      init_ok  = init && !old_full;
      take     = tick && old_full && (!m_busy || m_cnt == 159);
      m_done   = 0;
      if (init_ok) begin
        m_busy = 0; m_cnt = 0;
      end else if (tick) begin
        if (m_busy && m_cnt == 159) begin
          m_done = 1;
          if (take) begin m_sh = m_q.pop_front(); m_cnt = 0; end
          else begin m_busy = 0; m_cnt = 0; end
        end else if (m_busy) begin
          m_cnt++;
        end else if (take) begin
          m_sh = m_q.pop_front(); m_busy = 1; m_cnt = 0;
        end
      end
      if (take) m_full = 0;
      if (wr_en && !old_full) begin m_full = 1; m_q.push_back(wr_data); end
      if (wr_en && old_full) m_ovr = 1;
      else if (ovr_clr) m_ovr = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(tx_o == exp_tx(), "R4 tx_o", tx_o, exp_tx());
      chk(buf_full_o == m_full, "R2 buf_full", buf_full_o, m_full);
      chk(tx_busy_o == m_busy, "R5 busy", tx_busy_o, m_busy);
      chk(tx_done_o == m_done, "R9 done", tx_done_o, m_done);
      chk(overrun_o == m_ovr, "R8 overrun", overrun_o, m_ovr);
    end
    if (tick_en) begin
      tick_div = (tick_div + 1) % tick_per;
      tick <= (tick_div == 0);
    end else begin
      tick <= 1'b0;
    end
  end

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_en = 1; wr_data = b;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!tx_busy_o && !buf_full_o) break;
    end
  endtask

  initial begin
    #200000;
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(tx_o == 1 && !buf_full_o && !tx_busy_o && !tx_done_o && !overrun_o,
        "R1 reset", {tx_o, buf_full_o, tx_busy_o, tx_done_o, overrun_o}, 5'b10000);

    // R6 / R3 back-to-back
    tick_en = 1; tick_per = 1;
    wr(8'hA5);
    chk({buf_full_o, tx_busy_o} == 2'b10, "R6 seq 10", {buf_full_o, tx_busy_o}, 2);
    @(negedge clk);
    chk({buf_full_o, tx_busy_o} == 2'b01, "R3 seq 01", {buf_full_o, tx_busy_o}, 1);
    wr(8'h3C);
    chk({buf_full_o, tx_busy_o} == 2'b11, "R6 seq 11", {buf_full_o, tx_busy_o}, 3);
    for (int i = 0; i < 400 && buf_full_o; i++) @(negedge clk);
    chk({buf_full_o, tx_busy_o} == 2'b01, "R6 seq 01", {buf_full_o, tx_busy_o}, 1);
    wait_idle();

    // R7 overrun with ticks stopped
    tick_en = 0;
    repeat (2) @(negedge clk);
    wr(8'h11);
    wr(8'h22);
    chk(overrun_o == 1, "R7 overrun set", overrun_o, 1);
    @(negedge clk); ovr_clr = 1; @(negedge clk); ovr_clr = 0;
    chk(overrun_o == 0, "R8 clear", overrun_o, 0);
    // R10 init ignored while full
    @(negedge clk); init = 1; @(negedge clk); init = 0;
    chk(buf_full_o == 1, "R10 init ignored", buf_full_o, 1);
    // R8 set beats clear
    @(negedge clk); wr_en = 1; wr_data = 8'h77; ovr_clr = 1;
    @(negedge clk); wr_en = 0; ovr_clr = 0;
    chk(overrun_o == 1, "R8 set wins", overrun_o, 1);
    tick_en = 1;
    wait_idle();
    @(negedge clk); ovr_clr = 1; @(negedge clk); ovr_clr = 0;

    // R10 init mid-frame
    wr(8'hF0);
    repeat (60) @(negedge clk);
    init = 1; @(negedge clk); init = 0;
    chk(!tx_busy_o && tx_o, "R10 init abort", {tx_busy_o, tx_o}, 1);
    repeat (3) @(negedge clk);

    // sparse ticks, chained frames
    tick_per = 3;
    wr(8'h81);
    wr(8'h00);
    for (int i = 0; i < 2000 && buf_full_o; i++) @(negedge clk);
    wr(8'hFF);
    wait_idle();
    repeat (5) @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule